// File: doc/BRIEF.md
# Watermark-Driven Pause Frame Generator

This block sits between the receive side of a gigabit full-duplex point-to-point Ethernet link and local consumer logic. It takes a byte stream of raw frames, a MAC header followed directly by payload, and removes the header. The payload bytes go into an on-chip byte FIFO, and downstream logic reads them through a first-word-fall-through port. The first two payload bytes carry a 16-bit sequence number. The block compares each one with its predecessor so that lost frames can be flagged.

The block also protects the FIFO against overflow. When the registered fill count reaches three quarters of capacity, the block streams flow-control PAUSE frames back to back, each one asking for the maximum pause time. The frames go out on a byte-wide valid/ready transmit stream toward the MAC, which appends the FCS. The block keeps pausing until the fill drops below one half. It then emits a single PAUSE with a zero pause time so the peer resumes, and goes quiet. Between the two marks nothing changes. A frame that has started is always completed unchanged.

Top module: `pfc_pause_gen`

## Requirements
- R1: Bytes at frame positions 0 to HDR_LEN-1 (default 14, position 0 is the byte with start asserted) are not stored. Every later byte of the frame appears at the read port in arrival order, with head data valid whenever the FIFO is not empty.
- R2: A byte presented with valid while no frame is open is ignored. A frame is open from its start byte through its end byte inclusive.
- R3: A payload byte that arrives while the fill equals DEPTH is dropped and sets the sticky overflow output. Fill never exceeds DEPTH, and overflow stays low while the sender honours the pauses.
- R4: Once the fill is at least 3/4 of DEPTH, PAUSE frames carrying pause time 0xFFFF are sent with no idle cycle between them for as long as pausing holds.
- R5: Every PAUSE frame is 60 bytes, with last asserted on byte 59 only. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are the source MAC input, most significant byte first. Bytes 12-13 are 88 08. Bytes 14-15 are 00 01. Bytes 16-17 are the pause time, high byte first. Bytes 18-59 are zero.
- R6: After pausing starts, pause frames continue while the fill is between 1/2 and 3/4 of DEPTH. Once the fill is below 1/2, exactly one frame with pause time 0x0000 follows, and then no further frame is sent.
- R7: While a frame byte is offered and not accepted, the data and last outputs hold. A frame's pause-time bytes never change mid frame.
- R8: The sequence number is payload bytes SEQ_OFS and SEQ_OFS+1 (default 0, high byte first). A one-cycle gap pulse follows any number that is not the previous one plus one modulo 65536. The first frame after reset never pulses.
- R9: After reset the FIFO is empty with fill 0, no frame is offered, and the gap and overflow outputs are low.
- R10: No PAUSE frame is sent while the fill has stayed below 3/4 of DEPTH since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_mac_i | input | 48 | Source address placed in PAUSE frames |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Receive byte is first of frame |
| rx_eof_i | input | 1 | Receive byte is last of frame |
| rx_data_i | input | 8 | Receive byte |
| rd_en_i | input | 1 | Pop head byte of FIFO |
| rd_data_o | output | 8 | FIFO head byte |
| rd_empty_o | output | 1 | FIFO empty |
| fill_o | output | $clog2(DEPTH)+1 | Registered fill count |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Transmit byte ends frame |
| tx_ready_i | input | 1 | MAC accepts transmit byte |
| seq_gap_o | output | 1 | One-cycle sequence gap pulse |
| overflow_o | output | 1 | Sticky FIFO overflow |

## Verification
A corrupted byte position counter in the transmit path surfaces within one frame, either as last on a byte other than 59 or as a wrong constant at a fixed offset. A pause or resume flag stuck at the wrong value shows within one frame time (about 60 cycles) after a watermark crossing: as missing back-to-back frames, a missing or duplicated zero-time frame, or traffic that never stops. Pointer or count faults in the FIFO show as payload mismatches at the read port on the next drain, or as a fill value that disagrees with the number of bytes written. A wrong stored sequence number shows as a spurious or missing gap pulse on the cycle after the following frame's second sequence byte.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int          PAUSE_BYTES = 60;
  localparam logic [5:0]  LAST_IDX    = 6'(PAUSE_BYTES - 1);
  localparam logic [15:0] QUANTA_MAX  = 16'hFFFF;

  // byte i of a pause frame, FCS excluded
  function automatic logic [7:0] pause_byte(input logic [5:0] i, input logic [47:0] sa,
                                            input logic [15:0] q);
    logic [7:0] b;
    case (i)
      6'd0:  b = 8'h01;
      6'd1:  b = 8'h80;
      6'd2:  b = 8'hC2;
      6'd3:  b = 8'h00;
      6'd4:  b = 8'h00;
      6'd5:  b = 8'h01;
      6'd6:  b = sa[47:40];
      6'd7:  b = sa[39:32];
      6'd8:  b = sa[31:24];
      6'd9:  b = sa[23:16];
      6'd10: b = sa[15:8];
      6'd11: b = sa[7:0];
      6'd12: b = 8'h88;
      6'd13: b = 8'h08;
      6'd14: b = 8'h00;
      6'd15: b = 8'h01;
      6'd16: b = q[15:8];
      6'd17: b = q[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pfc_rx_parse.sv
module pfc_rx_parse #(
  parameter int HDR_LEN = 14,
  parameter int SEQ_OFS = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [7:0] data_i,
  output logic       wr_o,
  output logic       gap_o
);
  localparam logic [15:0] PAY_AT = 16'(HDR_LEN);
  localparam logic [15:0] SEQ_HI = 16'(HDR_LEN + SEQ_OFS);
  localparam logic [15:0] SEQ_LO = 16'(HDR_LEN + SEQ_OFS + 1);

  logic        in_frame_q, have_q, gap_q, take;
  logic [15:0] pos_q, cur_pos, prev_q, seq_now;
  logic [7:0]  seq_hi_q;

  assign take    = valid_i && (sof_i || in_frame_q);
  assign cur_pos = sof_i ? '0 : pos_q;
  assign seq_now = {seq_hi_q, data_i};
  assign wr_o    = take && (cur_pos >= PAY_AT);
  assign gap_o   = gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
      seq_hi_q   <= '0;
      prev_q     <= '0;
      have_q     <= 1'b0;
      gap_q      <= 1'b0;
    end else begin
      gap_q <= 1'b0;
      if (take) begin
        in_frame_q <= !eof_i;
        if (cur_pos != 16'hFFFF) pos_q <= cur_pos + 16'd1;
        if (cur_pos == SEQ_HI) seq_hi_q <= data_i;
        if (cur_pos == SEQ_LO) begin
          gap_q  <= have_q && (seq_now != prev_q + 16'd1);
          prev_q <= seq_now;
          have_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfc_fifo.sv
module pfc_fifo #(
  parameter  int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  data_i,
  input  logic        rd_i,
  output logic [7:0]  data_o,
  output logic        empty_o,
  output logic        full_o,
  output logic [AW:0] count_o,
  output logic        ovf_o
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          ovf_q, wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CAP);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign data_o  = mem_q[rp_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_i && full_o) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pfc_pause_tx.sv
module pfc_pause_tx
  import pfc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [47:0] src_mac_i,
  input  logic        go_i,
  input  logic [15:0] quanta_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  data_o,
  output logic        last_o,
  output logic        load_o
);
  logic        busy_q, done;
  logic [5:0]  idx_q;
  logic [15:0] quanta_q;

  assign done    = busy_q && ready_i && (idx_q == LAST_IDX);
  assign load_o  = go_i && (!busy_q || done);  // back-to-back restart
  assign valid_o = busy_q;
  assign last_o  = busy_q && (idx_q == LAST_IDX);
  assign data_o  = pause_byte(idx_q, src_mac_i, quanta_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      quanta_q <= '0;
    end else if (load_o) begin
      busy_q   <= 1'b1;
      idx_q    <= '0;
      quanta_q <= quanta_i;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q && ready_i) begin
      idx_q <= idx_q + 6'd1;
    end
  end
endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen
  import pfc_pkg::*;
#(
  parameter  int DEPTH   = 2048,
  parameter  int HDR_LEN = 14,
  parameter  int SEQ_OFS = 0,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [47:0] src_mac_i,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rd_en_i,
  output logic [7:0]  rd_data_o,
  output logic        rd_empty_o,
  output logic [AW:0] fill_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        seq_gap_o,
  output logic        overflow_o
);
  localparam logic [AW:0] HI_MARK = (AW+1)'(DEPTH * 3 / 4);
  localparam logic [AW:0] LO_MARK = (AW+1)'(DEPTH / 2);

  logic        wr, full, load, paused_q, resume_q;
  logic [AW:0] count;

  pfc_rx_parse #(.HDR_LEN(HDR_LEN), .SEQ_OFS(SEQ_OFS)) u_parse (
    .clk_i, .rst_ni,
    .valid_i (rx_valid_i),
    .sof_i   (rx_sof_i),
    .eof_i   (rx_eof_i),
    .data_i  (rx_data_i),
    .wr_o    (wr),
    .gap_o   (seq_gap_o)
  );

  pfc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i    (wr),
    .data_i  (rx_data_i),
    .rd_i    (rd_en_i),
    .data_o  (rd_data_o),
    .empty_o (rd_empty_o),
    .full_o  (full),
    .count_o (count),
    .ovf_o   (overflow_o)
  );

  assign fill_o = count;

  // hysteresis: set at >= 3/4, release below 1/2, hold in between
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q <= 1'b0;
      resume_q <= 1'b0;
    end else if (count >= HI_MARK) begin
      paused_q <= 1'b1;
      resume_q <= 1'b0;
    end else if (paused_q && count < LO_MARK) begin
      paused_q <= 1'b0;
      resume_q <= 1'b1;
    end else if (resume_q && load) begin
      resume_q <= 1'b0;
    end
  end

  pfc_pause_tx u_tx (
    .clk_i, .rst_ni,
    .src_mac_i,
    .go_i     (paused_q || resume_q),
    .quanta_i (paused_q ? QUANTA_MAX : 16'h0000),
    .ready_i  (tx_ready_i),
    .valid_o  (tx_valid_o),
    .data_o   (tx_data_o),
    .last_o   (tx_last_o),
    .load_o   (load)
  );

  logic unused_full;
  assign unused_full = full;
endmodule

// File: rtl/pfc_pause_gen_chk.sv
module pfc_pause_gen_chk #(
  parameter  int DEPTH = 2048,
  localparam int FW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          tx_last_o,
  input logic [FW-1:0] fill_o,
  input logic          overflow_o,
  input logic          seq_gap_o
);
  localparam logic [FW-1:0] CAP = FW'(DEPTH);
  localparam logic [FW-1:0] HI  = FW'(DEPTH * 3 / 4);

  // independent byte position within the outgoing frame
  logic [5:0] k_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) k_q <= '0;
    else if (tx_valid_o && tx_ready_i) k_q <= tx_last_o ? 6'd0 : k_q + 6'd1;
  end

  a_r5_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_last_o == (k_q == 6'd59)));
  a_r5_dst_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && k_q == 6'd0 |-> tx_data_o == 8'h01);
  a_r5_ethertype: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && k_q == 6'd12 |-> tx_data_o == 8'h88);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CAP);
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r8_gap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_gap_o |=> !seq_gap_o);
  a_r4_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o >= HI) && $past(fill_o >= HI) |=> tx_valid_o);
endmodule

bind pfc_pause_gen pfc_pause_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_last_o  (tx_last_o),
  .fill_o     (fill_o),
  .overflow_o (overflow_o),
  .seq_gap_o  (seq_gap_o)
);

// File: tb/pfc_pause_gen_test.sv
module pfc_pause_gen_test;
  localparam int DEPTH = 2048;
  localparam logic [47:0] SA = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        rd_empty_o;
  logic [11:0] fill_o;
  logic        tx_valid_o, tx_last_o, seq_gap_o, overflow_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b1;

  always #5 clk = ~clk;

  pfc_pause_gen #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni, .src_mac_i(SA),
    .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_data_i,
    .rd_en_i, .rd_data_o, .rd_empty_o, .fill_o,
    .tx_valid_o, .tx_data_o, .tx_last_o, .tx_ready_i,
    .seq_gap_o, .overflow_o
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  bit rd_on = 0, ready_toggle = 0;
  int gap_cnt = 0, n_frames = 0, n_xoff = 0, n_xon = 0, fn = 0;
  logic [15:0] last_quanta = '0;
  logic [7:0] fb [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [15:0] q);
    case (i)
      0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
      3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
      6: return SA[47:40]; 7: return SA[39:32]; 8: return SA[31:24];
      9: return SA[23:16]; 10: return SA[15:8]; 11: return SA[7:0];
      12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
      16: return q[15:8]; 17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // monitor: FIFO scoreboard, frame capture, gap count, ready pattern
  always @(negedge clk) begin
    if (rst_ni) begin
      if (seq_gap_o) gap_cnt++;
      if (rd_on && !rd_empty_o) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected fifo byte", rd_data_o, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data_o == e, "R1 fifo byte", rd_data_o, e);
        end
        rd_en_i = 1'b1;
      end else rd_en_i = 1'b0;
      if (tx_valid_o && tx_ready_i) begin
        if (fn < 64) fb[fn] = tx_data_o;
        fn++;
        if (tx_last_o) begin
          logic [15:0] q;
          int badpos;
          q = {fb[16], fb[17]};
          badpos = -1;
          for (int i = 59; i >= 0; i--) if (fb[i] != exp_byte(i, q)) badpos = i;
          chk(fn == 60, "R5 frame length", fn, 60);
          chk(badpos < 0, "R5 frame byte position", badpos, -1);
          chk(q == 16'hFFFF || q == 16'h0000, "R7 whole-frame quanta", q, 16'hFFFF);
          if (q == 16'h0000) n_xon++; else n_xoff++;
          last_quanta = q;
          n_frames++;
          fn = 0;
        end
      end
      tx_ready_i = ready_toggle ? !tx_ready_i : 1'b1;
    end
  end

  // driver: frame of header + payload, expected payload into scoreboard
  task automatic send_frame(input logic [15:0] seq, input int plen);
    int n;
    n = 14 + plen;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      int p;
      p = i - 14;
      if (i < 14) b = 8'hA0 + 8'(i);
      else if (p == 0) b = seq[15:8];
      else if (p == 1) b = seq[7:0];
      else b = 8'(p * 3) + seq[7:0];
      @(negedge clk);
      rx_valid_i = 1'b1; rx_sof_i = (i == 0); rx_eof_i = (i == n - 1); rx_data_i = b;
      if (i >= 14 && exp_q.size() < DEPTH) exp_q.push_back(b);
    end
    @(negedge clk);
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
  endtask

  task automatic send_stray(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_sof_i = 1'b0; rx_eof_i = 1'b0; rx_data_i = 8'hEE;
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    int t;
    rd_on = 1; t = 0;
    while (!(rd_empty_o && exp_q.size() == 0) && t < 5000) begin
      @(negedge clk); t++;
    end
    rd_on = 0;
    wait_cyc(2);
    chk(exp_q.size() == 0, "R1 all payload delivered", exp_q.size(), 0);
  endtask

  task automatic wait_fill_below(input int lim);
    int t;
    t = 0;
    while (int'(fill_o) >= lim && t < 5000) begin
      @(negedge clk); t++;
    end
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] seq;
    int nf;
    wait_cyc(5);
    rst_ni = 1'b1;
    wait_cyc(1);
    // R9 reset state
    chk(rd_empty_o == 1'b1, "R9 empty after reset", rd_empty_o, 1);
    chk(fill_o == 0, "R9 fill after reset", fill_o, 0);
    chk(tx_valid_o == 1'b0, "R9 no frame after reset", tx_valid_o, 0);
    chk(!overflow_o && !seq_gap_o, "R9 flags after reset", {overflow_o, seq_gap_o}, 0);

    // R1 header strip, R2 stray bytes between frames
    send_frame(16'd0, 20);
    send_stray(5);
    send_frame(16'd1, 20);
    wait_cyc(2);
    chk(fill_o == 40, "R2 stray bytes ignored, R1 header skipped", fill_o, 40);
    drain();
    chk(gap_cnt == 0, "R8 no gap on consecutive and first frame", gap_cnt, 0);

    // R8 gaps and modulo wrap
    send_frame(16'd5, 10);
    wait_cyc(3);
    chk(gap_cnt == 1, "R8 gap pulse on jump", gap_cnt, 1);
    send_frame(16'd6, 10);
    send_frame(16'hFFFF, 10);
    send_frame(16'h0000, 10);
    wait_cyc(3);
    chk(gap_cnt == 2, "R8 wrap is not a gap", gap_cnt, 2);
    drain();

    // R10 below high mark: silent
    seq = 16'd1;
    for (int f = 0; f < 7; f++) begin send_frame(seq, 200); seq++; end
    wait_cyc(10);
    chk(n_frames == 0 && !tx_valid_o, "R10 no pause below high mark", n_frames, 0);
    // R4 crossing the high mark
    send_frame(seq, 200); seq++;
    wait_cyc(5);
    chk(tx_valid_o == 1'b1, "R4 pause starts at high mark", tx_valid_o, 1);
    ready_toggle = 1;
    send_frame(seq, 100); seq++;
    wait_cyc(300);
    ready_toggle = 0;
    chk(n_xoff >= 2 && n_xon == 0, "R4 repeated max-time pauses", n_xoff, 2);
    // R6 hysteresis band, then single resume
    rd_on = 1;
    wait_fill_below(1300);
    chk(tx_valid_o == 1'b1, "R6 still pausing between marks", tx_valid_o, 1);
    wait_fill_below(1000);
    wait_cyc(200);
    chk(n_xon == 1, "R6 exactly one zero-time frame", n_xon, 1);
    chk(last_quanta == 16'h0000, "R6 last frame is resume", last_quanta, 0);
    chk(tx_valid_o == 1'b0, "R6 quiet after resume", tx_valid_o, 0);
    drain();
    nf = n_frames;
    wait_cyc(200);
    chk(n_frames == nf, "R6 no frames after resume", n_frames, nf);
    chk(overflow_o == 1'b0, "R3 no overflow when pauses honoured", overflow_o, 0);

    // R3 sender ignores pauses
    for (int f = 0; f < 7; f++) begin send_frame(seq, 300); seq++; end
    wait_cyc(2);
    chk(overflow_o == 1'b1, "R3 overflow flag", overflow_o, 1);
    chk(fill_o == DEPTH, "R3 fill capped", fill_o, DEPTH);
    drain();
    wait_cyc(200);
    chk(n_xon == 2, "R6 resume after overflow drain", n_xon, 2);
    chk(overflow_o == 1'b1, "R3 overflow sticky", overflow_o, 1);
    chk(gap_cnt == 2, "R8 no gap on in-order stream", gap_cnt, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule